// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one synchronisation cell shared by several hardware threads. It holds an unsigned count that threads take from and give to. Each access names a view, and the view decides what the access does. Two views perform semaphore operations, one blocking and one non-blocking. A read in a semaphore view is a take and a write is a give. A raw view reads the count without changing it. A control view reads and writes the status flags. Two queue views exist only for queue-type cells and do nothing here.

When a blocking take finds the count at zero, the cell answers with a stall response and records the requester in a parked mask. The requester then waits. The next give broadcasts a one-cycle wake pulse to every parked requester and clears the mask. The requester re-issues its take after the wake; re-issue is not part of this block. Writes arrive on a put port and reads on a get port. When both are valid in one cycle, the put is applied first and the get sees its result. Responses are registered and appear one clock after the get is accepted.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the E (bit 0), F (bit 1) and T (bit 16) flags are 0, the kind flag (bit 17) equals parameter IS_FIFO, and rsp_valid_o and wake_o are 0.
- R2: A get in semaphore view 4 or 5 on a nonzero count returns the count as it was before the get, in rsp_data_o[CNT_W-1:0] with the upper bits zero, and decrements the count. rsp_valid_o is high for exactly the cycle after the get is accepted.
- R3: A get in blocking view 4 at count zero returns rsp_stall_o=1 and rsp_data_o=0. The count is left at zero, and bit get_id_i of the parked mask is set.
- R4: A get in non-blocking view 5 at count zero returns 0 with no stall, and it records nothing: a later give's wake pulse does not include that requester.
- R5: A put in view 4 or 5 increments the count unless it is already 2^CNT_W-1 (0xFFFF by default), where the count holds. put_wdata_i is ignored.
- R6: Every put in view 4 or 5 drives wake_o, in the cycle after the put, to the parked mask as it stood before the put, and then clears the mask. This happens even when the count is saturated, and wake_o is 0 when the mask is empty.
- R7: When a put and a get are valid in the same cycle, the put takes effect first. For example, a blocking get at count zero together with a give returns 1, does not stall, and leaves the count at 0.
- R8: A get in raw view 0 returns the count unchanged. A put in view 0 has no effect.
- R9: A get in control view 1 returns E at bit 0, F at bit 1, T at bit 16 and the kind flag at bit 17, with all other bits 0. A put in view 1 loads E, F and T from put_wdata_i bits 0, 1 and 16 and leaves the count unchanged.
- R10: Queue views 2 and 3 return 0 on a get. A put in these views does not change the count and does not wake anyone.
- R11: With IS_FIFO=1, semaphore-view gets return 0 and never stall, and semaphore-view puts change nothing and produce no wake.
- R12: View codes are 0 raw, 1 control, 2 queue blocking, 3 queue non-blocking, 4 semaphore blocking and 5 semaphore non-blocking. Codes 6 and 7 return 0 and are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| put_valid_i | input | 1 | Write access present |
| put_view_i | input | 3 | View code of the write |
| put_wdata_i | input | DATA_W | Write data (used only by the control view) |
| get_valid_i | input | 1 | Read access present |
| get_view_i | input | 3 | View code of the read |
| get_id_i | input | ID_W | Requester number of the read |
| rsp_valid_o | output | 1 | Read response present |
| rsp_data_o | output | DATA_W | Read response data |
| rsp_stall_o | output | 1 | Read was a blocking take at zero; the requester is parked |
| wake_o | output | 2^ID_W | One-cycle wake pulse, one bit per requester |

## Verification
A give and a take can land in the same cycle, and so can a give and a take that parks a requester. The bench provokes this by asserting both ports together. It does so across every pair of put view and get view, at count zero, at count one and at the saturated count. Each case is judged against a reference model that applies the put before the get, which sets the expected response data, the stall flag and the wake vector. A dedicated case parks a requester first and then issues a give together with a blocking take. The wake must carry the parked bit, and the take must succeed on the freshly given count.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    typedef enum logic [2:0] {
        VW_RAW   = 3'd0,
        VW_CTRL  = 3'd1,
        VW_QWAIT = 3'd2,
        VW_QTRY  = 3'd3,
        VW_SWAIT = 3'd4,
        VW_STRY  = 3'd5
    } view_e;

    localparam int TAG_E_BIT    = 0;
    localparam int TAG_F_BIT    = 1;
    localparam int TAG_T_BIT    = 16;
    localparam int TAG_KIND_BIT = 17;

    typedef struct packed {
        logic raw;
        logic ctl;
        logic queue;
        logic sem;
        logic hold;
    } view_dec_t;

endpackage

// File: rtl/sem_cell_decode.sv
module sem_cell_decode
    import sem_cell_pkg::*;
(
    input  logic [2:0] view_i,
    output view_dec_t  dec_o
);

    always_comb begin
        dec_o = '0;
        case (view_i)
            VW_RAW:   dec_o.raw   = 1'b1;
            VW_CTRL:  dec_o.ctl   = 1'b1;
            VW_QWAIT: begin dec_o.queue = 1'b1; dec_o.hold = 1'b1; end
            VW_QTRY:  dec_o.queue = 1'b1;
            VW_SWAIT: begin dec_o.sem = 1'b1; dec_o.hold = 1'b1; end
            VW_STRY:  dec_o.sem   = 1'b1;
            default:  dec_o = '0;
        endcase
    end

endmodule

// File: rtl/sem_cell_wake.sv
module sem_cell_wake #(
    parameter int ID_W = 3,
    localparam int NREQ = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            give_i,
    input  logic            park_i,
    input  logic [ID_W-1:0] park_id_i,
    output logic [NREQ-1:0] wake_o
);

    typedef struct packed {
        logic [NREQ-1:0] mask;
        logic [NREQ-1:0] wake;
    } wake_st_t;

    wake_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = give_i ? st_q.mask : '0;
        if (give_i) begin
            st_d.mask = '0;
        end
        if (park_i) begin
            st_d.mask[park_id_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o = st_q.wake;

    // R6
    wake_after_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_o) |-> $past(give_i));

    // R3
    park_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_i |=> st_q.mask[$past(park_id_i)]);

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 32,
    parameter int ID_W    = 3,
    parameter bit IS_FIFO = 1'b0,
    localparam int NREQ   = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_valid_i,
    input  logic [2:0]        put_view_i,
    input  logic [DATA_W-1:0] put_wdata_i,
    input  logic              get_valid_i,
    input  logic [2:0]        get_view_i,
    input  logic [ID_W-1:0]   get_id_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rsp_stall_o,
    output logic [NREQ-1:0]   wake_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              e;
        logic              f;
        logic              t;
        logic              rsp_v;
        logic              rsp_stall;
        logic [DATA_W-1:0] rsp_data;
    } cell_st_t;

    cell_st_t  st_d, st_q;
    view_dec_t pdec, gdec;
    logic      give, park;
    logic      unused_bits;

    sem_cell_decode u_put_dec (.view_i(put_view_i), .dec_o(pdec));
    sem_cell_decode u_get_dec (.view_i(get_view_i), .dec_o(gdec));

    assign unused_bits = ^{put_wdata_i, pdec.raw, pdec.queue, pdec.hold, gdec.queue};

    always_comb begin
        st_d           = st_q;
        give           = 1'b0;
        park           = 1'b0;
        st_d.rsp_v     = get_valid_i;
        st_d.rsp_stall = 1'b0;
        st_d.rsp_data  = '0;
        // put stage first: fixed priority over the get
        if (put_valid_i) begin
            if (pdec.ctl) begin
                st_d.t = put_wdata_i[TAG_T_BIT];
                st_d.e = put_wdata_i[TAG_E_BIT];
                st_d.f = put_wdata_i[TAG_F_BIT];
            end
            if (pdec.sem && !IS_FIFO) begin
                give = 1'b1;
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
        // get stage sees the post-put state
        if (get_valid_i) begin
            if (gdec.raw) begin
                st_d.rsp_data = DATA_W'(st_d.cnt);
            end else if (gdec.ctl) begin
                st_d.rsp_data[TAG_E_BIT]    = st_d.e;
                st_d.rsp_data[TAG_F_BIT]    = st_d.f;
                st_d.rsp_data[TAG_T_BIT]    = st_d.t;
                st_d.rsp_data[TAG_KIND_BIT] = IS_FIFO;
            end else if (gdec.sem && !IS_FIFO) begin
                if (st_d.cnt != '0) begin
                    st_d.rsp_data = DATA_W'(st_d.cnt);
                    st_d.cnt      = st_d.cnt - 1'b1;
                end else if (gdec.hold) begin
                    st_d.rsp_stall = 1'b1;
                    park           = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sem_cell_wake #(.ID_W(ID_W)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .give_i    (give),
        .park_i    (park),
        .park_id_i (get_id_i),
        .wake_o    (wake_o)
    );

    assign rsp_valid_o = st_q.rsp_v;
    assign rsp_data_o  = st_q.rsp_data;
    assign rsp_stall_o = st_q.rsp_stall;

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put_valid_i && pdec.sem && st_q.cnt == CNT_MAX && !get_valid_i) |=> st_q.cnt == CNT_MAX);

    // R3
    stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall_o |-> (rsp_valid_o && rsp_data_o == '0 && st_q.cnt == '0));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!put_valid_i && !get_valid_i) |=> $stable(st_q.cnt));

    // R11
    kind_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_FIFO && rsp_valid_o) |-> !rsp_stall_o);

endmodule

// File: tb/sem_cell_bench.sv
module sem_cell_bench;

    localparam int CW  = 4;
    localparam int DW  = 32;
    localparam int IW  = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]    pv, gv;
    logic [2:0]    pview [2];
    logic [DW-1:0] pdata [2];
    logic [2:0]    gview [2];
    logic [IW-1:0] gid   [2];
    logic [1:0]    rv, rs;
    logic [DW-1:0] rd [2];
    logic [7:0]    wk [2];

    sem_cell #(.CNT_W(CW), .DATA_W(DW), .ID_W(IW), .IS_FIFO(1'b0)) u_sem_cell (
        .clk(clk), .rst_n(rst_n),
        .put_valid_i(pv[0]), .put_view_i(pview[0]), .put_wdata_i(pdata[0]),
        .get_valid_i(gv[0]), .get_view_i(gview[0]), .get_id_i(gid[0]),
        .rsp_valid_o(rv[0]), .rsp_data_o(rd[0]), .rsp_stall_o(rs[0]), .wake_o(wk[0]));

    sem_cell #(.CNT_W(CW), .DATA_W(DW), .ID_W(IW), .IS_FIFO(1'b1)) u_sem_cell_fifo (
        .clk(clk), .rst_n(rst_n),
        .put_valid_i(pv[1]), .put_view_i(pview[1]), .put_wdata_i(pdata[1]),
        .get_valid_i(gv[1]), .get_view_i(gview[1]), .get_id_i(gid[1]),
        .rsp_valid_o(rv[1]), .rsp_data_o(rd[1]), .rsp_stall_o(rs[1]), .wake_o(wk[1]));

    int npass = 0;
    int ntot  = 0;
    bit done  = 1'b0;

    int       m_cnt [2];
    logic [7:0] m_mask [2];
    logic     m_e [2], m_f [2], m_t [2];

    task automatic check(input bit ok, input string req, input string what);
        ntot++;
        if (ok) npass++;
        else $display("FAIL %s: %s", req, what);
    endtask

    // one access cycle on cell s; model applies put before get
    task automatic op(input int s, input bit p_v, input logic [2:0] p_vw, input logic [DW-1:0] p_d,
                      input bit g_v, input logic [2:0] g_vw, input logic [IW-1:0] g_id,
                      input string req);
        logic [DW-1:0] ed;
        logic          es;
        logic [7:0]    ew;
        ed = '0; es = 1'b0; ew = '0;
        if (p_v) begin
            if (p_vw == 3'd1) begin
                m_t[s] = p_d[16]; m_e[s] = p_d[0]; m_f[s] = p_d[1];
            end
            if ((p_vw == 3'd4 || p_vw == 3'd5) && s == 0) begin
                ew = m_mask[s]; m_mask[s] = '0;
                if (m_cnt[s] < MAXC) m_cnt[s]++;
            end
        end
        if (g_v) begin
            case (g_vw)
                3'd0: ed = DW'(m_cnt[s]);
                3'd1: ed = (DW'(m_t[s]) << 16) | (DW'(s) << 17) | (DW'(m_f[s]) << 1) | DW'(m_e[s]);
                3'd4, 3'd5: if (s == 0) begin
                    if (m_cnt[s] > 0) begin
                        ed = DW'(m_cnt[s]); m_cnt[s]--;
                    end else if (g_vw == 3'd4) begin
                        es = 1'b1; m_mask[s][g_id] = 1'b1;
                    end
                end
                default: ed = '0;
            endcase
        end
        @(negedge clk);
        pv[s] = p_v; pview[s] = p_vw; pdata[s] = p_d;
        gv[s] = g_v; gview[s] = g_vw; gid[s] = g_id;
        @(posedge clk);
        #1;
        check(rv[s] == g_v && rd[s] == ed && rs[s] == es && wk[s] == ew, req,
              $sformatf("cell%0d valid=%0b data=%h stall=%0b wake=%h exp valid=%0b data=%h stall=%0b wake=%h",
                        s, rv[s], rd[s], rs[s], wk[s], g_v, ed, es, ew));
        @(negedge clk);
        pv[s] = 1'b0; gv[s] = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", npass, ntot);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "run did not finish, exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        pv = '0; gv = '0;
        for (int s = 0; s < 2; s++) begin
            pview[s] = '0; pdata[s] = '0; gview[s] = '0; gid[s] = '0;
            m_cnt[s] = 0; m_mask[s] = '0; m_e[s] = 0; m_f[s] = 0; m_t[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        check(rv == 2'b00 && wk[0] == 8'h00 && wk[1] == 8'h00, "R1",
              $sformatf("rsp_valid=%b wake=%h exp 00 00", rv, wk[0]));
        op(0, 0, 3'd0, '0, 1, 3'd1, 3'd0, "R1");
        op(0, 0, 3'd0, '0, 1, 3'd0, 3'd0, "R1");
        op(1, 0, 3'd0, '0, 1, 3'd1, 3'd0, "R1");
        // R4 non-blocking take at zero records nothing
        op(0, 0, 3'd0, '0, 1, 3'd5, 3'd2, "R4");
        op(0, 1, 3'd5, 32'hDEAD_BEEF, 0, 3'd0, 3'd0, "R4");
        op(0, 0, 3'd0, '0, 1, 3'd5, 3'd0, "R2");
        // R5 fill to saturation with varied data
        for (int i = 0; i < MAXC + 4; i++)
            op(0, 1, (i % 2) ? 3'd4 : 3'd5, DW'(i * 32'h1234_5677), 0, 3'd0, 3'd0, "R5");
        op(0, 0, 3'd0, '0, 1, 3'd0, 3'd0, "R8");
        // R6 give at saturation with empty mask
        op(0, 1, 3'd4, '0, 0, 3'd0, 3'd0, "R6");
        // R2 drain, each read returns the pre-take count
        for (int i = 0; i < MAXC + 2; i++)
            op(0, 0, 3'd0, '0, 1, (i % 2) ? 3'd4 : 3'd5, IW'(i), (i > MAXC) ? "R3" : "R2");
        // R3 park every requester, R6 broadcast wake
        for (int id = 0; id < 8; id++)
            op(0, 0, 3'd0, '0, 1, 3'd4, IW'(id), "R3");
        op(0, 1, 3'd5, '0, 0, 3'd0, 3'd0, "R6");
        op(0, 1, 3'd5, '0, 0, 3'd0, 3'd0, "R6");
        op(0, 0, 3'd0, '0, 1, 3'd5, 3'd0, "R2");
        op(0, 0, 3'd0, '0, 1, 3'd5, 3'd0, "R2");
        // R7 same-cycle give and blocking take
        op(0, 1, 3'd4, '0, 1, 3'd4, 3'd3, "R7");
        op(0, 0, 3'd0, '0, 1, 3'd4, 3'd6, "R7");
        op(0, 1, 3'd5, '0, 1, 3'd4, 3'd1, "R7");
        op(0, 0, 3'd0, '0, 1, 3'd0, 3'd0, "R7");
        // R8 raw write ignored
        op(0, 1, 3'd4, '0, 0, 3'd0, 3'd0, "R8");
        op(0, 1, 3'd0, 32'h0000_0007, 1, 3'd0, 3'd0, "R8");
        op(0, 0, 3'd0, '0, 1, 3'd0, 3'd0, "R8");
        // R9 control view
        op(0, 1, 3'd1, 32'hFFFF_FFFF, 1, 3'd1, 3'd0, "R9");
        op(0, 0, 3'd0, '0, 1, 3'd0, 3'd0, "R9");
        op(0, 1, 3'd1, 32'h0001_0000, 1, 3'd1, 3'd0, "R9");
        op(0, 1, 3'd1, 32'h0000_0002, 1, 3'd1, 3'd0, "R9");
        op(0, 1, 3'd1, '0, 0, 3'd0, 3'd0, "R9");
        // R10 queue views: no effect, no wake with a parked requester
        op(0, 0, 3'd0, '0, 1, 3'd5, 3'd0, "R10");
        op(0, 0, 3'd0, '0, 1, 3'd4, 3'd4, "R10");
        op(0, 1, 3'd2, 32'h1, 1, 3'd2, 3'd0, "R10");
        op(0, 1, 3'd3, 32'h1, 1, 3'd3, 3'd0, "R10");
        op(0, 1, 3'd4, '0, 0, 3'd0, 3'd0, "R10");
        // R12 exhaustive view pairs at counts 0, 1 and saturated
        for (int c = 0; c < 3; c++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    int target;
                    target = (c == 0) ? 0 : (c == 1) ? 1 : MAXC;
                    while (m_cnt[0] < target) op(0, 1, 3'd5, '0, 0, 3'd0, 3'd0, "R12");
                    while (m_cnt[0] > target) op(0, 0, 3'd0, '0, 1, 3'd5, 3'd0, "R12");
                    op(0, 1, 3'(a), DW'(a * 32'h0001_0003), 1, 3'(b), IW'(a + b), "R12");
                end
            end
        end
        // R11 queue-type cell: semaphore views inert
        op(1, 1, 3'd4, '0, 0, 3'd0, 3'd0, "R11");
        op(1, 1, 3'd5, '0, 1, 3'd4, 3'd2, "R11");
        op(1, 0, 3'd0, '0, 1, 3'd5, 3'd0, "R11");
        op(1, 0, 3'd0, '0, 1, 3'd0, 3'd0, "R11");
        op(1, 1, 3'd1, 32'h0001_0001, 1, 3'd1, 3'd0, "R11");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule